// File: doc/BRIEF.md
# Timer Capture, Compare and PWM Channel

This block is one channel of a general-purpose timer. A free-running up-counter with a programmable wrap value sits outside the channel. The channel reads the counter value and receives a one-cycle overflow strobe from it. The channel can run in one of four modes:

- It captures the counter value on a chosen edge of an external input.
- It compares the counter against a single register and acts on the output pin.
- It compares the counter against a double-buffered register pair, which gives glitch-free pulse-width modulation.
- It is idle, and the pin rests at a preset level under port control.

Software programs the channel through two write strobes. One strobe loads a configuration word: a 4-bit mode field, a toggle-on-overflow bit and a force-full-duty bit. The other strobe loads a compare value. Each match or capture raises a one-cycle event pulse, which interrupt logic elsewhere can collect.

When toggle-on-overflow is set, the pin also changes at every counter overflow. This gives PWM: the pin goes to its active level at the start of each period and returns at the compare point. The force-full-duty bit holds the pin at the active level for whole periods. It is sampled only at overflow, so it takes effect, and releases, at the next period boundary.

Top module: `tmr_chan`

## Requirements
- R1: After reset the pin output is 1, the event pulse is 0 and the channel value is 0.
- R2: Mode field {mb, ma, eb, ea} with eb:ea = 00 makes the channel idle. A configuration write then presets the pin to 1 when ma = 0 and to 0 when ma = 1. Counter events leave the pin unchanged. With mb:ma = 01 a compare match still pulses the event output.
- R3: With mb:ma = 00 and eb:ea not 00, the channel captures. eb:ea = 01 captures on rising input edges, 10 on falling edges and 11 on both. The input passes through two synchronizer stages. A transition driven before clock edge N loads the counter value present at edge N+2 into the channel value, and the event pulse is high after that edge.
- R4: In capture mode the pin does not change, even at overflow with toggle-on-overflow set.
- R5: With mb:ma = 01 (unbuffered compare), a match between counter and channel value acts on the pin at that clock edge: eb:ea = 01 toggles, 10 clears, 11 sets.
- R6: In unbuffered mode a compare-value write replaces the active compare value at once.
- R7: With mb = 1 (buffered compare), a write goes to the shadow register. The channel value and the compare point change only at the next overflow.
- R8: In either compare mode with toggle-on-overflow set, the pin inverts at each overflow strobe.
- R9: When an overflow with toggle-on-overflow set and a compare match occur in the same cycle, the pin inverts and the compare action is dropped.
- R10: Setting force-full-duty (with toggle-on-overflow set, compare mode) has no effect until the next overflow. From that overflow the pin holds the active level for whole periods.
- R11: Clearing force-full-duty keeps the pin at the active level until the next overflow. Normal PWM resumes after that overflow.
- R12: The forced level is 0 when eb:ea = 11 (set on compare) and 1 for eb:ea = 10 or 01.
- R13: The event output is high for exactly one cycle per match or capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Loads the configuration fields |
| cfg_mode | input | 4 | Mode field {mb, ma, eb, ea} |
| cfg_tov | input | 1 | Toggle-on-overflow enable |
| cfg_max | input | 1 | Force-full-duty request |
| cmp_we | input | 1 | Loads the compare value |
| cmp_wdata | input | CNT_W | Compare value |
| cnt | input | CNT_W | Shared counter value |
| ovf | input | 1 | One-cycle counter wrap strobe |
| cap_in | input | 1 | Asynchronous capture input |
| pin_out | output | 1 | Channel output pin |
| evt | output | 1 | One-cycle match or capture event |
| chan_val | output | CNT_W | Active compare value or last captured count |

## Verification
The counter overflow and a compare match can land on the same clock edge. This happens whenever the compare value equals the counter's wrap value. The bench sets up that collision in the set-on-compare mode with the pin at 1, and again in the clear-on-compare mode with the pin at 0. In both cases the compare action would leave the pin unchanged, so only an inversion proves that the overflow won. The same collision also occurs while the buffered pair swaps at overflow. There the bench checks the pin inverts and that the swap does not misplace the new compare value.

// File: rtl/tmr_chan_pkg.sv
// Package for the timer channel: mode kinds and decode helpers.
// Assumes the mode field layout {mb, ma, eb, ea}, msb first.
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_CAP  = 2'd1,
        CH_OCU  = 2'd2,
        CH_OCB  = 2'd3
    } ch_kind_e;

    typedef struct packed {
        logic ms_b;
        logic ms_a;
        logic el_b;
        logic el_a;
    } ch_mode_t;

    // Pin actions carried in the edge/level pair
    localparam logic [1:0] PA_TOGGLE = 2'b01;
    localparam logic [1:0] PA_CLEAR  = 2'b10;
    localparam logic [1:0] PA_SET    = 2'b11;

    // Map a mode field onto the channel kind
    function automatic ch_kind_e decode_kind(input ch_mode_t m);
        if ({m.el_b, m.el_a} == 2'b00) return CH_IDLE;
        else if (m.ms_b)                return CH_OCB;
        else if (m.ms_a)                return CH_OCU;
        else                            return CH_CAP;
    endfunction

endpackage

// File: rtl/tmr_cap_edge.sv
// Capture input conditioner.
// Passes the asynchronous input through SYNC_STAGES flops, keeps one more
// flop as the history bit, and raises hit for one cycle on the selected
// edge(s). Assumes edge_sel is 01 rising, 10 falling, 11 both.
module tmr_cap_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_in,
    input  logic       enable,
    input  logic [1:0] edge_sel,
    output logic       hit
);
    localparam int unsigned DEPTH = SYNC_STAGES + 1;

    logic [DEPTH-1:0] shift_q;
    logic             rise;
    logic             fall;

    // Shift the raw input through the synchronizer and history flop
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= '0;
        else        shift_q <= {shift_q[DEPTH-2:0], cap_in};
    end

    // Edge decode between the last synchronized bit and its history
    always_comb begin
        rise = shift_q[DEPTH-2] & ~shift_q[DEPTH-1];
        fall = ~shift_q[DEPTH-2] & shift_q[DEPTH-1];
        hit  = enable & ((edge_sel[0] & rise) | (edge_sel[1] & fall));
    end

endmodule

// File: rtl/tmr_cmp_bank.sv
// Compare register pair with active/shadow selection.
// Unbuffered: writes and captures go to the active entry.
// Buffered: writes go to the shadow entry; the entries swap at overflow
// when a write is pending. Assumes cap_hit only occurs outside buffered mode.
module tmr_cmp_bank #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             buf_mode,
    input  logic             cap_hit,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovf,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] act_val,
    output logic             cnt_eq
);
    localparam int unsigned BANKS = 2;

    logic [CNT_W-1:0] bank_q [BANKS];
    logic             sel_q;
    logic             pend_q;

    // Load the entries from capture or software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BANKS; b++) bank_q[b] <= '0;
        end else if (cap_hit) begin
            bank_q[sel_q] <= cnt;
        end else if (wr_en) begin
            if (buf_mode) bank_q[~sel_q] <= wr_data;
            else          bank_q[sel_q]  <= wr_data;
        end
    end

    // Track pending shadow data and swap at the period boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (!buf_mode) begin
            pend_q <= 1'b0;
        end else if (ovf && (pend_q || wr_en)) begin
            sel_q  <= ~sel_q;
            pend_q <= 1'b0;
        end else if (wr_en) begin
            pend_q <= 1'b1;
        end
    end

    // Active value and the raw equality
    always_comb begin
        act_val = bank_q[sel_q];
        cnt_eq  = (cnt == act_val);
    end

    // R7: buffered compare point moves only at overflow
    assert_buf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && !ovf) |=> $stable(act_val));

    // R3: a capture loads the counter sampled at the capture edge
    assert_cap_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> (act_val == $past(cnt)));

endmodule

// File: rtl/tmr_pin_ctrl.sv
// Output pin logic for the channel.
// Holds the pin register, applies preset, overflow toggle and compare
// actions, and masks the pin with the full-duty level. The full-duty
// request is sampled only at overflow. Assumes hit is the raw equality
// and oc marks either compare mode.
module tmr_pin_ctrl
    import tmr_chan_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       preset_we,
    input  logic       preset_lvl,
    input  logic       oc,
    input  logic       cap_mode,
    input  logic [1:0] act,
    input  logic       tov,
    input  logic       max_req,
    input  logic       ovf,
    input  logic       hit,
    output logic       pin_out
);
    logic pin_q;
    logic max_eff_q;
    logic full_lvl;
    logic forced;

    // Update the underlying pin level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q <= 1'b1;
        end else if (preset_we) begin
            pin_q <= preset_lvl;
        end else if (oc) begin
            if (ovf && tov) begin
                pin_q <= ~pin_q;
            end else if (hit) begin
                case (act)
                    PA_TOGGLE: pin_q <= ~pin_q;
                    PA_CLEAR:  pin_q <= 1'b0;
                    PA_SET:    pin_q <= 1'b1;
                    default:   pin_q <= pin_q;
                endcase
            end
        end
    end

    // Sample the full-duty request at each period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)   max_eff_q <= 1'b0;
        else if (ovf) max_eff_q <= max_req;
    end

    // Choose the forced level and drive the pin
    always_comb begin
        full_lvl = (act == PA_SET) ? 1'b0 : 1'b1;
        forced   = oc & tov & max_eff_q;
        pin_out  = forced ? full_lvl : pin_q;
    end

    // R8: overflow inverts the pin in compare modes
    assert_tov_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (oc && tov && ovf && !cfg_we) |=> (pin_q != $past(pin_q)));

    // R9: overflow beats a clear that lands in the same cycle
    assert_ovf_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (oc && tov && ovf && hit && act == PA_CLEAR && !pin_q && !cfg_we) |=> pin_q);

    // R4: capture mode never moves the pin
    assert_cap_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_mode && !cfg_we) |=> $stable(pin_q));

    // R10: after a boundary with the request set the pin shows the full level
    assert_max_entry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && max_req && oc && tov && !cfg_we) |=> (pin_out == $past(full_lvl)));

    // R2: an idle channel keeps its pin
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!oc && !cfg_we) |=> $stable(pin_q));

endmodule

// File: rtl/tmr_chan.sv
// Timer channel top: configuration register, mode decode, and the
// capture, compare bank and pin submodules. Assumes cnt and ovf come from
// a shared counter in the same clock domain, with ovf high in the cycle
// that cnt holds the wrap value.
module tmr_chan
    import tmr_chan_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [3:0]       cfg_mode,
    input  logic             cfg_tov,
    input  logic             cfg_max,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             ovf,
    input  logic             cap_in,
    output logic             pin_out,
    output logic             evt,
    output logic [CNT_W-1:0] chan_val
);
    ch_mode_t mode_q;
    ch_mode_t mode_new;
    ch_kind_e kind;
    logic     tov_q;
    logic     max_q;
    logic     sw_cmp;
    logic     oc;
    logic     cap_mode;
    logic     cmp_hit;
    logic     cap_hit;
    logic     cnt_eq;
    logic     preset_we;
    logic     evt_q;

    // Hold the configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            tov_q  <= 1'b0;
            max_q  <= 1'b0;
        end else if (cfg_we) begin
            mode_q <= ch_mode_t'(cfg_mode);
            tov_q  <= cfg_tov;
            max_q  <= cfg_max;
        end
    end

    // Decode the mode and qualify events
    always_comb begin
        mode_new  = ch_mode_t'(cfg_mode);
        kind      = decode_kind(mode_q);
        sw_cmp    = (kind == CH_IDLE) && mode_q.ms_a && !mode_q.ms_b;
        oc        = (kind == CH_OCU) || (kind == CH_OCB);
        cap_mode  = (kind == CH_CAP);
        cmp_hit   = (oc || sw_cmp) && cnt_eq;
        preset_we = cfg_we && ({mode_new.el_b, mode_new.el_a} == 2'b00);
    end

    tmr_cap_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_in   (cap_in),
        .enable   (cap_mode),
        .edge_sel ({mode_q.el_b, mode_q.el_a}),
        .hit      (cap_hit)
    );

    tmr_cmp_bank #(
        .CNT_W (CNT_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_mode (kind == CH_OCB),
        .cap_hit  (cap_hit),
        .cnt      (cnt),
        .ovf      (ovf),
        .wr_en    (cmp_we),
        .wr_data  (cmp_wdata),
        .act_val  (chan_val),
        .cnt_eq   (cnt_eq)
    );

    tmr_pin_ctrl u_pin (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .preset_we  (preset_we),
        .preset_lvl (~mode_new.ms_a),
        .oc         (oc),
        .cap_mode   (cap_mode),
        .act        ({mode_q.el_b, mode_q.el_a}),
        .tov        (tov_q),
        .max_req    (max_q),
        .ovf        (ovf),
        .hit        (cnt_eq),
        .pin_out    (pin_out)
    );

    // Register the event pulse
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= cmp_hit | cap_hit;
    end

    assign evt = evt_q;

    // R13: a capture always produces an event on the next cycle
    assert_cap_evt_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cap_hit |=> evt);

endmodule

// File: tb/sim_tmr_chan.sv
// Scoreboard bench for tmr_chan: the driver pushes expected samples tagged
// with a cycle number, and the monitor pops and compares them.
`timescale 1ns/1ps
module sim_tmr_chan;
    localparam int W   = 8;
    localparam int MOD = 15;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [3:0]   cfg_mode = 4'b0;
    logic         cfg_tov = 1'b0;
    logic         cfg_max = 1'b0;
    logic         cmp_we = 1'b0;
    logic [W-1:0] cmp_wdata = '0;
    logic [W-1:0] cnt = '0;
    logic         ovf;
    logic         cap_in = 1'b0;
    logic         pin_out;
    logic         evt;
    logic [W-1:0] chan_val;

    logic         run = 1'b0;
    logic         ld = 1'b0;
    logic [W-1:0] ldv = '0;
    int           cyc = 0;
    int           n_cmp = 0;
    int           n_bad = 0;
    bit           done = 1'b0;

    typedef struct {
        int    at;
        int    sig;
        int    exp;
        string tag;
    } sb_item_t;
    sb_item_t sbq[$];

    always #4 clk = ~clk;

    tmr_chan #(.CNT_W(W), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_tov(cfg_tov), .cfg_max(cfg_max), .cmp_we(cmp_we),
        .cmp_wdata(cmp_wdata), .cnt(cnt), .ovf(ovf), .cap_in(cap_in),
        .pin_out(pin_out), .evt(evt), .chan_val(chan_val)
    );

    // Shared counter model, moved on the falling edge
    always @(negedge clk) begin
        if (ld)       cnt <= ldv;
        else if (run) cnt <= (cnt == W'(MOD)) ? '0 : cnt + 1'b1;
    end
    assign ovf = run && (cnt == W'(MOD));

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item due in this cycle
    always @(negedge clk) begin
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].at == cyc) begin
                int act;
                case (sbq[i].sig)
                    0:       act = int'(pin_out);
                    1:       act = int'(evt);
                    default: act = int'(chan_val);
                endcase
                n_cmp++;
                if (act != sbq[i].exp) begin
                    n_bad++;
                    $display("FAIL %s sig=%0d cyc=%0d actual=%0h expected=%0h",
                             sbq[i].tag, sbq[i].sig, cyc, act, sbq[i].exp);
                end
                sbq.delete(i);
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic expect_at(input int dc, input int sig, input int v, input string tag);
        sb_item_t it;
        it.at = cyc + dc; it.sig = sig; it.exp = v; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic cfg(input logic [3:0] m, input logic t, input logic mx);
        cfg_we = 1'b1; cfg_mode = m; cfg_tov = t; cfg_max = mx;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic wr_cmp(input int v);
        cmp_we = 1'b1; cmp_wdata = W'(v);
        step();
        cmp_we = 1'b0;
    endtask

    task automatic wait_cnt(input int v);
        while (cnt != W'(v)) step();
    endtask

    task automatic set_cnt(input int v);
        ld = 1'b1; ldv = W'(v);
        step();
        ld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            n_bad += sbq.size();
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
        finish_run();
    end

    // Driver
    initial begin
        repeat (4) step();
        rst_n = 1'b1;
        expect_at(1, 0, 1, "R1 pin");
        expect_at(1, 1, 0, "R1 evt");
        expect_at(1, 2, 0, "R1 val");
        step();

        // R2: idle presets and software compare
        cfg(4'b0100, 1'b0, 1'b0);
        expect_at(1, 0, 0, "R2 preset low");
        wr_cmp(5);
        run = 1'b1;
        wait_cnt(5);
        expect_at(1, 1, 1, "R2 sw compare evt");
        expect_at(1, 0, 0, "R2 pin untouched");
        expect_at(2, 1, 0, "R13 pulse width");
        step(); step();
        cfg(4'b1000, 1'b0, 1'b0);
        expect_at(1, 0, 1, "R2 preset high mb");
        step();
        cfg(4'b1100, 1'b0, 1'b0);
        expect_at(1, 0, 0, "R2 preset low mb");
        step();

        // R5: unbuffered pin actions, pin starts at 0
        cfg(4'b0101, 1'b0, 1'b0);
        wait_cnt(5);
        expect_at(1, 0, 1, "R5 toggle");
        expect_at(1, 1, 1, "R13 compare evt");
        step();
        cfg(4'b0110, 1'b0, 1'b0);
        wait_cnt(5);
        expect_at(1, 0, 0, "R5 clear");
        step();
        cfg(4'b0111, 1'b0, 1'b0);
        wait_cnt(5);
        expect_at(1, 0, 1, "R5 set");
        step();

        // R6: immediate compare update, clear mode
        cfg(4'b0110, 1'b0, 1'b0);
        wait_cnt(2);
        cmp_we = 1'b1; cmp_wdata = 8'd9;
        expect_at(1, 2, 9, "R6 value now");
        step();
        cmp_we = 1'b0;
        wait_cnt(5);
        expect_at(1, 0, 1, "R6 old point dead");
        step();
        wait_cnt(9);
        expect_at(1, 0, 0, "R6 new point");
        step();

        // R8: toggle at overflow, clear at 9
        cfg(4'b0110, 1'b1, 1'b0);
        wait_cnt(MOD);
        expect_at(1, 0, 1, "R8 ovf toggle");
        step();
        wait_cnt(9);
        expect_at(1, 0, 0, "R8 clear after");
        step();
        wait_cnt(MOD);
        expect_at(1, 0, 1, "R8 ovf toggle again");
        step();

        // R9: collisions with compare at the wrap value
        cfg(4'b0111, 1'b1, 1'b0);
        wr_cmp(MOD);
        wait_cnt(MOD);
        expect_at(1, 0, 0, "R9 ovf beats set");
        expect_at(1, 1, 1, "R13 collision evt");
        step();
        cfg(4'b0110, 1'b1, 1'b0);
        wait_cnt(MOD);
        expect_at(1, 0, 1, "R9 ovf beats clear");
        step();

        // R7: buffered write waits for the boundary
        cfg(4'b1010, 1'b1, 1'b0);
        wait_cnt(1);
        cmp_we = 1'b1; cmp_wdata = 8'd3;
        expect_at(1, 2, MOD, "R7 shadow hidden");
        step();
        cmp_we = 1'b0;
        wait_cnt(3);
        expect_at(1, 0, 1, "R7 no early clear");
        step();
        wait_cnt(MOD);
        expect_at(1, 0, 0, "R9 ovf at swap");
        expect_at(1, 2, 3, "R7 swapped");
        step();
        wait_cnt(MOD);
        expect_at(1, 0, 1, "R8 period start");
        step();
        wait_cnt(3);
        expect_at(1, 0, 0, "R7 new point");
        step();

        // R10: force full duty, takes a period to apply
        wait_cnt(6);
        cfg(4'b1010, 1'b1, 1'b1);
        wait_cnt(14);
        expect_at(1, 0, 0, "R10 not yet");
        step();
        wait_cnt(MOD);
        expect_at(1, 0, 1, "R10 applied");
        step();
        wait_cnt(3);
        expect_at(1, 0, 1, "R10 held past compare");
        step();

        // R11: release also waits for the boundary
        wait_cnt(6);
        cfg(4'b1010, 1'b1, 1'b0);
        wait_cnt(10);
        expect_at(1, 0, 1, "R11 still held");
        step();
        wait_cnt(MOD);
        expect_at(1, 0, 1, "R11 period start");
        step();
        wait_cnt(3);
        expect_at(1, 0, 0, "R11 released");
        step();

        // R12: set-on-compare forces low
        wait_cnt(5);
        cfg(4'b1011, 1'b1, 1'b1);
        wait_cnt(MOD);
        expect_at(1, 0, 0, "R12 low level");
        step();
        wait_cnt(3);
        expect_at(1, 0, 0, "R12 held past set");
        step();

        // R4: capture mode ignores overflow toggling
        cfg(4'b0000, 1'b0, 1'b0);
        cfg(4'b0001, 1'b1, 1'b0);
        wait_cnt(MOD);
        expect_at(1, 0, 1, "R4 pin kept");
        step();

        // R3: edge selection with a frozen counter
        run = 1'b0;
        set_cnt(8'h2A);
        cap_in = 1'b1;
        expect_at(3, 1, 1, "R3 rise evt");
        expect_at(3, 2, 8'h2A, "R3 rise value");
        expect_at(4, 1, 0, "R13 capture pulse");
        repeat (6) step();
        set_cnt(8'h33);
        cap_in = 1'b0;
        expect_at(3, 1, 0, "R3 fall ignored");
        expect_at(4, 2, 8'h2A, "R3 value kept");
        repeat (6) step();

        cfg(4'b0010, 1'b0, 1'b0);
        repeat (3) step();
        cap_in = 1'b1;
        expect_at(3, 1, 0, "R3 rise ignored");
        repeat (6) step();
        set_cnt(8'h44);
        cap_in = 1'b0;
        expect_at(3, 1, 1, "R3 fall evt");
        expect_at(3, 2, 8'h44, "R3 fall value");
        repeat (6) step();

        cfg(4'b0011, 1'b0, 1'b0);
        repeat (3) step();
        set_cnt(8'h55);
        cap_in = 1'b1;
        expect_at(3, 2, 8'h55, "R3 both rise");
        repeat (6) step();
        set_cnt(8'h66);
        cap_in = 1'b0;
        expect_at(3, 2, 8'h66, "R3 both fall");
        expect_at(3, 1, 1, "R3 both evt");
        repeat (8) step();

        finish_run();
    end

endmodule